// File: doc/BRIEF.md
# Serial Synthesizer Programming Port

This block takes configuration words for a frequency synthesizer over a three-pin serial link: a data pin, a shift clock pin and a load-enable pin. All three pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer. A rising edge on the synchronized shift clock moves one data bit into a shift register, most significant bit first.

When load-enable rises, the block reads the bit in the lowest position of the shift register. This is the last bit that was shifted in, and it acts as the control bit. A high control bit sends the word to the reference latch. That latch holds the prescaler select bit and a 14-bit reference ratio. A low control bit sends the word to the divider latch. That latch holds an 11-bit main count and a 7-bit swallow count. Only the selected latch is written. A one-cycle strobe marks the new value.

Three kinds of ratio are not allowed: a reference ratio below 8, a main count below 16, and a swallow count that is not smaller than the main count. Any of these sets a sticky error flag, and the value is still latched. The latched fields drive the reference divider, the prescaler and the main divider elsewhere on the chip.

Top module: `serial_synth_cfg`

## Requirements
- R1: After reset, every latched field is zero, `errFlag` is 0 and neither strobe pulses.
- R2: Each rising edge of the synchronized shift clock shifts in exactly one bit, MSB first. Bits shifted in before the last 19 fall out. For a reference word, only the last 16 bits count.
- R3: If shift-register bit 0 is 1 when load-enable rises, the word goes to the reference latch. Bit 15 becomes `prescSel` and bits 14..1 become `refRatio`. On the wire the word is the select bit, then R14..R1, then the control bit 1.
- R4: If shift-register bit 0 is 0 when load-enable rises, the word goes to the divider latch. Bits 18..8 become `mainCount` and bits 7..1 become `swalCount`. On the wire the word is N11..N1, then A7..A1, then the control bit 0.
- R5: A load to one latch leaves the fields of the other latch unchanged.
- R6: Each rising edge of load-enable gives exactly one one-cycle pulse. The pulse appears on `refLoaded` or on `divLoaded`, depending on the destination. Holding load-enable high does not reload.
- R7: `prescDiv` is 64 when `prescSel` is 1 (divide by 64/65) and 128 when `prescSel` is 0 (divide by 128/129).
- R8: A reference load with a ratio below 8 sets `errFlag`, and the ratio is still latched. The flag stays set until reset, even after later legal loads.
- R9: A divider load with a main count below 16 sets `errFlag`.
- R10: A divider load whose swallow count is greater than or equal to its main count sets `errFlag`.
- R11: The boundary values do not set the flag: a reference ratio of 8, and a main count of 16 with a swallow count of 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkPin | input | 1 | Serial shift clock, asynchronous |
| sdataPin | input | 1 | Serial data, asynchronous |
| lePin | input | 1 | Load enable, asynchronous |
| prescSel | output | 1 | Latched prescaler select bit |
| prescDiv | output | 8 | Low prescaler modulus (64 or 128) |
| refRatio | output | 14 | Latched reference ratio |
| mainCount | output | 11 | Latched main count |
| swalCount | output | 7 | Latched swallow count |
| refLoaded | output | 1 | One-cycle strobe: reference latch written |
| divLoaded | output | 1 | One-cycle strobe: divider latch written |
| errFlag | output | 1 | Sticky flag for illegal ratios |

## Verification
The bench sends words of two different lengths back to back, and checks after each load that the other latch has not moved. A design that picks the destination from the wrong bit, or that copies the whole register into both latches, would corrupt the other latch.

A junk prefix before a reference word checks that only the trailing bits count. A design that decodes fields from the top of the register would read the junk instead.

The exact boundaries are tested: a ratio of 8, a main count of 16 with a swallow count of 15, and a swallow count equal to the main count. These catch an off-by-one compare.

A long load-enable pulse and later legal loads check that the error flag stays set and that there is one strobe per edge. A design that detects levels instead of edges would give extra strobes, and one that clears the flag would lose it.

// File: rtl/serial_synth_cfg_pkg.sv
package serial_synth_cfg_pkg;
  typedef struct packed {
    logic shiftEn;
    logic latchRef;
    logic latchDiv;
  } cfgStrobes_t;
endpackage

// File: rtl/serial_synth_cfg_sync.sv
module serial_synth_cfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[0] <= '0;
        else       stage[0] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/serial_synth_cfg_ctrl.sv
module serial_synth_cfg_ctrl
  import serial_synth_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkSync,
  input  logic        leSync,
  input  logic        ctlBit,
  output cfgStrobes_t strobes
);
  logic sclkPrev;
  logic lePrev;
  logic leRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      lePrev   <= 1'b0;
    end else begin
      sclkPrev <= sclkSync;
      lePrev   <= leSync;
    end
  end

  assign leRise = leSync & ~lePrev;

  always_comb begin
    strobes          = '0;
    strobes.shiftEn  = sclkSync & ~sclkPrev;
    strobes.latchRef = leRise & ctlBit;
    strobes.latchDiv = leRise & ~ctlBit;
  end
endmodule

// File: rtl/serial_synth_cfg_dp.sv
module serial_synth_cfg_dp
  import serial_synth_cfg_pkg::*;
#(
  parameter int REF_BITS   = 14,
  parameter int MAIN_BITS  = 11,
  parameter int SWAL_BITS  = 7,
  parameter int REF_MIN    = 8,
  parameter int MAIN_MIN   = 16,
  parameter int PRESC_W    = 8,
  parameter int PRESC_FAST = 64,
  parameter int PRESC_SLOW = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dataSync,
  input  cfgStrobes_t          strobes,
  output logic                 ctlBit,
  output logic                 prescSel,
  output logic [PRESC_W-1:0]   prescDiv,
  output logic [REF_BITS-1:0]  refRatio,
  output logic [MAIN_BITS-1:0] mainCount,
  output logic [SWAL_BITS-1:0] swalCount,
  output logic                 refLoaded,
  output logic                 divLoaded,
  output logic                 errFlag
);
  localparam int SHIFT_W  = MAIN_BITS + SWAL_BITS + 1;
  localparam int SEL_POS  = REF_BITS + 1;
  localparam int MAIN_LSB = SWAL_BITS + 1;
  localparam logic [REF_BITS-1:0]  REF_MIN_V  = REF_BITS'(REF_MIN);
  localparam logic [MAIN_BITS-1:0] MAIN_MIN_V = MAIN_BITS'(MAIN_MIN);

  logic [SHIFT_W-1:0]   shiftReg;
  logic [REF_BITS-1:0]  newRef;
  logic [MAIN_BITS-1:0] newMain;
  logic [SWAL_BITS-1:0] newSwal;
  logic                 refBad;
  logic                 divBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[SHIFT_W-2:0], dataSync};
  end

  assign ctlBit  = shiftReg[0];
  assign newRef  = shiftReg[REF_BITS:1];
  assign newSwal = shiftReg[SWAL_BITS:1];
  assign newMain = shiftReg[SHIFT_W-1:MAIN_LSB];
  assign refBad  = newRef < REF_MIN_V;
  assign divBad  = (newMain < MAIN_MIN_V) || (MAIN_BITS'(newSwal) >= newMain);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescSel <= 1'b0;
      refRatio <= '0;
    end else if (strobes.latchRef) begin
      prescSel <= shiftReg[SEL_POS];
      refRatio <= newRef;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCount <= '0;
      swalCount <= '0;
    end else if (strobes.latchDiv) begin
      mainCount <= newMain;
      swalCount <= newSwal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refLoaded <= 1'b0;
      divLoaded <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      refLoaded <= strobes.latchRef;
      divLoaded <= strobes.latchDiv;
      if ((strobes.latchRef && refBad) || (strobes.latchDiv && divBad))
        errFlag <= 1'b1;
    end
  end

  assign prescDiv = prescSel ? PRESC_W'(PRESC_FAST) : PRESC_W'(PRESC_SLOW);
endmodule

// File: rtl/serial_synth_cfg.sv
module serial_synth_cfg
  import serial_synth_cfg_pkg::*;
#(
  parameter int REF_BITS    = 14,
  parameter int MAIN_BITS   = 11,
  parameter int SWAL_BITS   = 7,
  parameter int REF_MIN     = 8,
  parameter int MAIN_MIN    = 16,
  parameter int PRESC_W     = 8,
  parameter int PRESC_FAST  = 64,
  parameter int PRESC_SLOW  = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclkPin,
  input  logic                 sdataPin,
  input  logic                 lePin,
  output logic                 prescSel,
  output logic [PRESC_W-1:0]   prescDiv,
  output logic [REF_BITS-1:0]  refRatio,
  output logic [MAIN_BITS-1:0] mainCount,
  output logic [SWAL_BITS-1:0] swalCount,
  output logic                 refLoaded,
  output logic                 divLoaded,
  output logic                 errFlag
);
  logic [2:0]  pinSync;
  logic        ctlBit;
  cfgStrobes_t strobes;

  serial_synth_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({lePin, sdataPin, sclkPin}),
    .syncOut (pinSync)
  );

  serial_synth_cfg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclkSync (pinSync[0]),
    .leSync   (pinSync[2]),
    .ctlBit   (ctlBit),
    .strobes  (strobes)
  );

  serial_synth_cfg_dp #(
    .REF_BITS(REF_BITS), .MAIN_BITS(MAIN_BITS), .SWAL_BITS(SWAL_BITS),
    .REF_MIN(REF_MIN), .MAIN_MIN(MAIN_MIN), .PRESC_W(PRESC_W),
    .PRESC_FAST(PRESC_FAST), .PRESC_SLOW(PRESC_SLOW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dataSync  (pinSync[1]),
    .strobes   (strobes),
    .ctlBit    (ctlBit),
    .prescSel  (prescSel),
    .prescDiv  (prescDiv),
    .refRatio  (refRatio),
    .mainCount (mainCount),
    .swalCount (swalCount),
    .refLoaded (refLoaded),
    .divLoaded (divLoaded),
    .errFlag   (errFlag)
  );
endmodule

// File: rtl/serial_synth_cfg_chk.sv
module serial_synth_cfg_chk #(
  parameter int REF_BITS  = 14,
  parameter int MAIN_BITS = 11,
  parameter int SWAL_BITS = 7,
  parameter int REF_MIN   = 8,
  parameter int MAIN_MIN  = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [REF_BITS-1:0]  refRatio,
  input logic [MAIN_BITS-1:0] mainCount,
  input logic [SWAL_BITS-1:0] swalCount,
  input logic                 refLoaded,
  input logic                 divLoaded,
  input logic                 errFlag
);
  a_r6_single_dest: assert property (@(posedge clk) disable iff (!rstN)
    !(refLoaded && divLoaded));

  a_r6_ref_pulse: assert property (@(posedge clk) disable iff (!rstN)
    refLoaded |=> !refLoaded);

  a_r6_div_pulse: assert property (@(posedge clk) disable iff (!rstN)
    divLoaded |=> !divLoaded);

  a_r5_ref_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(refRatio) |-> refLoaded);

  a_r5_div_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({mainCount, swalCount}) |-> divLoaded);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  a_r8_ref_low: assert property (@(posedge clk) disable iff (!rstN)
    (refLoaded && (32'(refRatio) < REF_MIN)) |-> errFlag);

  a_r9_main_low: assert property (@(posedge clk) disable iff (!rstN)
    (divLoaded && (32'(mainCount) < MAIN_MIN)) |-> errFlag);

  a_r10_swal_ge: assert property (@(posedge clk) disable iff (!rstN)
    (divLoaded && (32'(swalCount) >= 32'(mainCount))) |-> errFlag);
endmodule

bind serial_synth_cfg serial_synth_cfg_chk #(
  .REF_BITS(REF_BITS), .MAIN_BITS(MAIN_BITS), .SWAL_BITS(SWAL_BITS),
  .REF_MIN(REF_MIN), .MAIN_MIN(MAIN_MIN)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .refRatio  (refRatio),
  .mainCount (mainCount),
  .swalCount (swalCount),
  .refLoaded (refLoaded),
  .divLoaded (divLoaded),
  .errFlag   (errFlag)
);

// File: tb/serial_synth_cfg_test.sv
module serial_synth_cfg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkPin = 1'b0;
  logic        sdataPin = 1'b0;
  logic        lePin = 1'b0;
  logic        prescSel;
  logic [7:0]  prescDiv;
  logic [13:0] refRatio;
  logic [10:0] mainCount;
  logic [6:0]  swalCount;
  logic        refLoaded;
  logic        divLoaded;
  logic        errFlag;

  int checks = 0;
  int errors = 0;
  int refPulses = 0;
  int divPulses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_synth_cfg uut (
    .clk(clk), .rstN(rstN), .sclkPin(sclkPin), .sdataPin(sdataPin),
    .lePin(lePin), .prescSel(prescSel), .prescDiv(prescDiv),
    .refRatio(refRatio), .mainCount(mainCount), .swalCount(swalCount),
    .refLoaded(refLoaded), .divLoaded(divLoaded), .errFlag(errFlag)
  );

  always @(posedge clk) begin
    if (rstN && refLoaded) refPulses++;
    if (rstN && divLoaded) divPulses++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sclkPin = 1'b0; sdataPin = 1'b0; lePin = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic shiftBits(input logic [31:0] word, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk); sdataPin = word[i];
      repeat (3) @(negedge clk); sclkPin = 1'b1;
      repeat (4) @(negedge clk); sclkPin = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic pulseLe(input int highCycles);
    @(negedge clk); lePin = 1'b1;
    repeat (highCycles) @(negedge clk);
    lePin = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sendRef(input bit sel, input int ratio);
    shiftBits({16'd0, sel, 14'(ratio), 1'b1}, 16);
    pulseLe(8);
  endtask

  task automatic sendDiv(input int n, input int a);
    shiftBits({13'd0, 11'(n), 7'(a), 1'b0}, 19);
    pulseLe(8);
  endtask

  task automatic t_reset_state();
    doReset();
    check(refRatio == 0 && prescSel == 0, "R1 ref fields", refRatio, 0);
    check(mainCount == 0 && swalCount == 0, "R1 div fields", mainCount, 0);
    check(errFlag == 0, "R1 errFlag", errFlag, 0);
    check(refPulses == 0 && divPulses == 0, "R1 strobes", refPulses + divPulses, 0);
  endtask

  task automatic t_boundaries();
    sendRef(1'b1, 8);
    check(refRatio == 8, "R11 ref ratio 8", refRatio, 8);
    sendDiv(16, 15);
    check(mainCount == 16 && swalCount == 15, "R11 div 16/15", mainCount, 16);
    check(errFlag == 0, "R11 boundary no error", errFlag, 0);
  endtask

  task automatic t_ref_load();
    int r0 = refPulses;
    int d0 = divPulses;
    sendRef(1'b0, 16383);
    check(refRatio == 16383, "R3 ref ratio", refRatio, 16383);
    check(prescSel == 0, "R3 presc select", prescSel, 0);
    check(prescDiv == 128, "R7 slow modulus", prescDiv, 128);
    check(mainCount == 16 && swalCount == 15, "R5 div untouched", mainCount, 16);
    check(refPulses == r0 + 1 && divPulses == d0, "R6 ref strobe", refPulses - r0, 1);
  endtask

  task automatic t_div_load();
    int r0 = refPulses;
    int d0 = divPulses;
    sendDiv(1234, 101);
    check(mainCount == 1234, "R4 main count", mainCount, 1234);
    check(swalCount == 101, "R4 swallow count", swalCount, 101);
    check(refRatio == 16383 && prescSel == 0, "R5 ref untouched", refRatio, 16383);
    check(divPulses == d0 + 1 && refPulses == r0, "R6 div strobe", divPulses - d0, 1);
  endtask

  task automatic t_prefix_and_hold();
    int r0 = refPulses;
    shiftBits(32'h1F, 5);
    shiftBits({16'd0, 1'b1, 14'd100, 1'b1}, 16);
    pulseLe(40);
    check(refRatio == 100, "R2 prefix discarded", refRatio, 100);
    check(prescSel == 1 && prescDiv == 64, "R7 fast modulus", prescDiv, 64);
    check(refPulses == r0 + 1, "R6 long LE one strobe", refPulses - r0, 1);
    check(mainCount == 1234 && swalCount == 101, "R5 div kept", swalCount, 101);
  endtask

  task automatic t_ref_illegal();
    doReset();
    sendRef(1'b0, 7);
    check(refRatio == 7, "R8 illegal still latched", refRatio, 7);
    check(errFlag == 1, "R8 ratio below 8", errFlag, 1);
    sendRef(1'b0, 50);
    check(errFlag == 1 && refRatio == 50, "R8 sticky", errFlag, 1);
  endtask

  task automatic t_div_illegal();
    doReset();
    sendDiv(15, 0);
    check(errFlag == 1, "R9 main below 16", errFlag, 1);
    doReset();
    sendDiv(20, 19);
    check(errFlag == 0, "R10 swallow below main ok", errFlag, 0);
    sendDiv(20, 20);
    check(errFlag == 1 && swalCount == 20, "R10 swallow equals main", errFlag, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_boundaries();
    t_ref_load();
    t_div_load();
    t_prefix_and_hold();
    t_ref_illegal();
    t_div_illegal();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule